// File: doc/BRIEF.md
# Load-Store Ordering and Disambiguation Queue

This block holds every in-flight memory operation in program order and decides, cycle by cycle, which of them may touch the data cache. Decode allocates one entry per load or store and receives the entry index back. Address generation later reports each effective address against that index. A load is released to the cache only when every older store in the queue has a known address that differs from the load's own. A store is released only once the pipeline has marked it committed, so a fault in any older instruction can still be recovered without undoing a memory write.

The queue is a circular buffer of `DEPTH` entries, 8 by default and a power of two, with head and tail pointers that carry one extra wrap bit. Committed stores leave from the head in order, at most one per cycle. A load that has been sent to the cache leaves when it reaches the head. On a branch mispredict the pipeline names the oldest entry to discard. That entry and everything younger are dropped, and the tail moves back to it. Data forwarding from stores to loads, address arithmetic and the cache itself are outside this block.

The reset input is asynchronous and active low. Its release is assumed to be synchronous to `clk` already.

Top module: `lsq_disambig`

## Requirements
- R1: After reset the queue is empty: `full` is 0, `alloc_idx` is 0, and neither `ld_issue_valid` nor `st_issue_valid` is asserted.
- R2: An allocation is taken on a rising edge when `alloc_valid` is 1, `full` is 0 and `flush_valid` is 0. The index it receives is the value of `alloc_idx` in that cycle. Successive allocations get consecutive indices modulo `DEPTH`.
- R3: `full` is 1 exactly when `DEPTH` entries are live. An allocation attempted while `full` is 1 changes nothing: once one entry has left, the next allocation still receives the index that was pending before the attempt.
- R4: A load whose address is known and that has no older store in the queue is shown on `ld_issue_valid`, `ld_issue_idx` and `ld_issue_addr` in the cycle after the edge that captured its address. It is shown for exactly one cycle.
- R5: An older store whose address is still unknown blocks every younger load. Once that store's address arrives and differs from the load's address, the load issues in the cycle after that address was captured.
- R6: An older store whose full address equals a load's address blocks that load until the store has left the queue.
- R7: A store drives `st_issue_valid`, `st_issue_idx` and `st_issue_addr` only while it is the oldest entry, its address is known and it is committed. It leaves the queue on that edge, so stores drain in program order at no more than one per cycle.
- R8: A store at the head that has not been committed never drains, even when a younger store has already been committed.
- R9: A flush with `flush_valid` = 1 and `flush_idx` = k discards entry k and every younger entry. Those entries never issue, even if an address update names them later. The next allocation receives k. No issue, update or commit takes effect in the flush cycle.
- R10: When several loads are eligible, the oldest issues first and the rest follow one per cycle.
- R11: A load that has issued leaves the queue once it is the oldest entry, and this frees its slot for allocation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Request a new entry in program order |
| alloc_store | input | 1 | 1 = the new entry is a store, 0 = a load |
| alloc_idx | output | IW | Index the next allocation will receive |
| full | output | 1 | All entries are live |
| addr_valid | input | 1 | An effective address is ready |
| addr_idx | input | IW | Entry that the address belongs to |
| addr_value | input | AW | Effective address (full word) |
| commit_valid | input | 1 | Mark a store as non-speculative |
| commit_idx | input | IW | Entry being committed |
| flush_valid | input | 1 | Discard entries from `flush_idx` to the tail |
| flush_idx | input | IW | Oldest entry to discard |
| ld_issue_valid | output | 1 | A load is sent to the cache this cycle |
| ld_issue_idx | output | IW | Entry of the issuing load |
| ld_issue_addr | output | AW | Address of the issuing load |
| st_issue_valid | output | 1 | A store writes memory this cycle |
| st_issue_idx | output | IW | Entry of the draining store |
| st_issue_addr | output | AW | Address of the draining store |

## Verification
Every output comes from registered queue state, so a load's issue strobe appears in the cycle after the edge that captured its last needed address. A store's drain strobe appears in the cycle after the edge that captured its commit, or that removed the older blocker. The bench drives inputs just after a rising edge and samples on the falling edge. Its driver pushes an expected index and address into a load queue or a store queue before the stimulus that releases them. The monitor pops one item for every strobe it sees at a falling edge. This catches early, late, repeated and reordered issues, and any strobe that arrives while its queue is empty. The idle stretches inside each test are long enough for pending strobes and head pops to finish. Each test ends by checking that both queues are empty.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

  // Per-entry status kept beside the address.
  typedef struct packed {
    logic is_st;    // entry is a store
    logic addr_ok;  // effective address captured
    logic cmt;      // store marked non-speculative
    logic done;     // load already sent to the cache
  } lsq_flag_t;

endpackage

// File: rtl/lsq_ptr_ctl.sv
module lsq_ptr_ctl #(
  parameter  int DEPTH = 8,
  localparam int IW    = $clog2(DEPTH),
  localparam int PW    = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  logic [IW-1:0] flush_idx,
  output logic [PW-1:0] head_ptr,
  output logic [PW-1:0] tail_ptr,
  output logic [PW-1:0] used,
  output logic          full
);

  logic [PW-1:0] head_q, head_nx, tail_q, tail_nx;
  logic [IW-1:0] keep;
  logic          head_en, tail_en;

  always_comb begin
    keep    = flush_idx - head_q[IW-1:0];
    head_nx = head_q + PW'(1);
    head_en = pop;
    tail_en = flush | push;
    if (flush) tail_nx = head_q + {1'b0, keep};
    else       tail_nx = tail_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
    end else if (head_en) begin
      head_q <= head_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q <= '0;
    end else if (tail_en) begin
      tail_q <= tail_nx;
    end
  end

  assign head_ptr = head_q;
  assign tail_ptr = tail_q;
  assign used     = tail_q - head_q;
  assign full     = (used == PW'(DEPTH));

endmodule

// File: rtl/lsq_entry_bank.sv
module lsq_entry_bank
  import lsq_pkg::*;
#(
  parameter  int DEPTH = 8,
  parameter  int AW    = 32,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_en,
  input  logic [IW-1:0]            alloc_idx,
  input  logic                     alloc_st,
  input  logic                     upd_en,
  input  logic [IW-1:0]            upd_idx,
  input  logic [AW-1:0]            upd_addr,
  input  logic                     cmt_en,
  input  logic [IW-1:0]            cmt_idx,
  input  logic                     ld_fire,
  input  logic [IW-1:0]            ld_idx,
  output logic [DEPTH-1:0]         is_st,
  output logic [DEPTH-1:0]         addr_ok,
  output logic [DEPTH-1:0]         cmt,
  output logic [DEPTH-1:0]         done,
  output logic [DEPTH-1:0][AW-1:0] addr
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    lsq_flag_t     flag_q, flag_nx;
    logic [AW-1:0] addr_q;
    logic          hit_alloc, hit_upd, hit_cmt, hit_ld, flag_en;

    always_comb begin
      hit_alloc = alloc_en && (alloc_idx == IW'(g));
      hit_upd   = upd_en   && (upd_idx   == IW'(g));
      hit_cmt   = cmt_en   && (cmt_idx   == IW'(g));
      hit_ld    = ld_fire  && (ld_idx    == IW'(g));
      flag_en   = hit_alloc | hit_upd | hit_cmt | hit_ld;
      flag_nx   = flag_q;
      if (hit_alloc) begin
        flag_nx = '{is_st: alloc_st, addr_ok: 1'b0, cmt: 1'b0, done: 1'b0};
      end else begin
        if (hit_upd) flag_nx.addr_ok = 1'b1;
        if (hit_cmt) flag_nx.cmt     = 1'b1;
        if (hit_ld)  flag_nx.done    = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q <= '0;
      end else if (flag_en) begin
        flag_q <= flag_nx;
      end
    end

    // Address storage is datapath only: written under enable, not reset.
    always_ff @(posedge clk) begin
      if (hit_upd && !hit_alloc) begin
        addr_q <= upd_addr;
      end
    end

    assign is_st[g]   = flag_q.is_st;
    assign addr_ok[g] = flag_q.addr_ok;
    assign cmt[g]     = flag_q.cmt;
    assign done[g]    = flag_q.done;
    assign addr[g]    = addr_q;
  end

endmodule

// File: rtl/lsq_load_sel.sv
module lsq_load_sel #(
  parameter  int DEPTH = 8,
  parameter  int AW    = 32,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic [IW-1:0]            head_idx,
  input  logic [DEPTH-1:0]         live,
  input  logic [DEPTH-1:0]         is_st,
  input  logic [DEPTH-1:0]         addr_ok,
  input  logic [DEPTH-1:0]         done,
  input  logic [DEPTH-1:0][AW-1:0] addr,
  output logic                     pick_valid,
  output logic [IW-1:0]            pick_idx
);

  logic [DEPTH-1:0][IW-1:0] age;
  logic [DEPTH-1:0]         elig;

  for (genvar g = 0; g < DEPTH; g++) begin : g_age
    assign age[g] = IW'(g) - head_idx;
  end

  // A load is eligible when no older live store is unresolved or aliases it.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      elig[i] = live[i] && !is_st[i] && addr_ok[i] && !done[i];
      for (int j = 0; j < DEPTH; j++) begin
        if (live[j] && is_st[j] && (age[j] < age[i]) &&
            (!addr_ok[j] || (addr[j] == addr[i]))) begin
          elig[i] = 1'b0;
        end
      end
    end
  end

  // Oldest eligible load wins: scan from youngest to oldest, last hit stays.
  always_comb begin
    logic [IW-1:0] pos;
    pick_valid = 1'b0;
    pick_idx   = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      pos = head_idx + IW'(k);
      if (elig[pos]) begin
        pick_valid = 1'b1;
        pick_idx   = pos;
      end
    end
  end

endmodule

// File: rtl/lsq_disambig.sv
module lsq_disambig #(
  parameter  int DEPTH = 8,
  parameter  int AW    = 32,
  localparam int IW    = $clog2(DEPTH),
  localparam int PW    = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  input  logic          alloc_store,
  output logic [IW-1:0] alloc_idx,
  output logic          full,
  input  logic          addr_valid,
  input  logic [IW-1:0] addr_idx,
  input  logic [AW-1:0] addr_value,
  input  logic          commit_valid,
  input  logic [IW-1:0] commit_idx,
  input  logic          flush_valid,
  input  logic [IW-1:0] flush_idx,
  output logic          ld_issue_valid,
  output logic [IW-1:0] ld_issue_idx,
  output logic [AW-1:0] ld_issue_addr,
  output logic          st_issue_valid,
  output logic [IW-1:0] st_issue_idx,
  output logic [AW-1:0] st_issue_addr
);

  logic [PW-1:0]            head_ptr, tail_ptr, used;
  logic [IW-1:0]            head_idx;
  logic [DEPTH-1:0]         live, is_st, addr_ok, cmt, done;
  logic [DEPTH-1:0][AW-1:0] addr;
  logic                     take, pop, st_go, ld_head_gone, pick_valid, ld_go;
  logic                     upd_en, cmt_en;
  logic [IW-1:0]            pick_idx;

  assign head_idx = head_ptr[IW-1:0];

  for (genvar g = 0; g < DEPTH; g++) begin : g_live
    logic [IW-1:0] off;
    assign off     = IW'(g) - head_idx;
    assign live[g] = ({1'b0, off} < used);
  end

  // A flush cycle freezes everything except the tail pointer.
  assign take         = alloc_valid && !full && !flush_valid;
  assign upd_en       = addr_valid && !flush_valid;
  assign cmt_en       = commit_valid && !flush_valid;
  assign st_go        = !flush_valid && live[head_idx] && is_st[head_idx] &&
                        addr_ok[head_idx] && cmt[head_idx];
  assign ld_head_gone = !flush_valid && live[head_idx] && !is_st[head_idx] &&
                        done[head_idx];
  assign pop          = st_go || ld_head_gone;
  assign ld_go        = !flush_valid && pick_valid;

  lsq_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (take),
    .pop       (pop),
    .flush     (flush_valid),
    .flush_idx (flush_idx),
    .head_ptr  (head_ptr),
    .tail_ptr  (tail_ptr),
    .used      (used),
    .full      (full)
  );

  lsq_entry_bank #(.DEPTH(DEPTH), .AW(AW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (take),
    .alloc_idx (tail_ptr[IW-1:0]),
    .alloc_st  (alloc_store),
    .upd_en    (upd_en),
    .upd_idx   (addr_idx),
    .upd_addr  (addr_value),
    .cmt_en    (cmt_en),
    .cmt_idx   (commit_idx),
    .ld_fire   (ld_go),
    .ld_idx    (pick_idx),
    .is_st     (is_st),
    .addr_ok   (addr_ok),
    .cmt       (cmt),
    .done      (done),
    .addr      (addr)
  );

  lsq_load_sel #(.DEPTH(DEPTH), .AW(AW)) u_sel (
    .head_idx   (head_idx),
    .live       (live),
    .is_st      (is_st),
    .addr_ok    (addr_ok),
    .done       (done),
    .addr       (addr),
    .pick_valid (pick_valid),
    .pick_idx   (pick_idx)
  );

  assign alloc_idx      = tail_ptr[IW-1:0];
  assign ld_issue_valid = ld_go;
  assign ld_issue_idx   = pick_idx;
  assign ld_issue_addr  = addr[pick_idx];
  assign st_issue_valid = st_go;
  assign st_issue_idx   = head_idx;
  assign st_issue_addr  = addr[head_idx];

endmodule

// File: rtl/lsq_disambig_chk.sv
module lsq_disambig_chk #(
  parameter  int DEPTH = 8,
  localparam int IW    = $clog2(DEPTH),
  localparam int PW    = IW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alloc_valid,
  input logic          full,
  input logic          flush_valid,
  input logic [IW-1:0] flush_idx,
  input logic          ld_issue_valid,
  input logic [IW-1:0] ld_issue_idx,
  input logic          st_issue_valid,
  input logic [PW-1:0] head_ptr,
  input logic [PW-1:0] tail_ptr
);

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (PW'(tail_ptr - head_ptr) <= PW'(DEPTH)));

  assert_full_ignores_alloc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && full && !flush_valid) |=> (tail_ptr == $past(tail_ptr)));

  assert_alloc_advances_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !full && !flush_valid) |=> (tail_ptr == $past(tail_ptr) + PW'(1)));

  assert_flush_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> (!ld_issue_valid && !st_issue_valid));

  assert_flush_tail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> (tail_ptr[IW-1:0] == $past(flush_idx)));

  assert_store_pops_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_issue_valid |=> (head_ptr == $past(head_ptr) + PW'(1)));

  assert_load_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_issue_valid |=> !(ld_issue_valid && (ld_issue_idx == $past(ld_issue_idx))));

endmodule

bind lsq_disambig lsq_disambig_chk #(.DEPTH(DEPTH)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .alloc_valid    (alloc_valid),
  .full           (full),
  .flush_valid    (flush_valid),
  .flush_idx      (flush_idx),
  .ld_issue_valid (ld_issue_valid),
  .ld_issue_idx   (ld_issue_idx),
  .st_issue_valid (st_issue_valid),
  .head_ptr       (head_ptr),
  .tail_ptr       (tail_ptr)
);

// File: tb/test_lsq_disambig.sv
module test_lsq_disambig;

  typedef struct packed {
    logic [2:0]  idx;
    logic [31:0] addr;
  } item_t;

  logic        clk, rst_n;
  logic        alloc_valid, alloc_store, full;
  logic [2:0]  alloc_idx;
  logic        addr_valid;
  logic [2:0]  addr_idx;
  logic [31:0] addr_value;
  logic        commit_valid;
  logic [2:0]  commit_idx;
  logic        flush_valid;
  logic [2:0]  flush_idx;
  logic        ld_issue_valid, st_issue_valid;
  logic [2:0]  ld_issue_idx, st_issue_idx;
  logic [31:0] ld_issue_addr, st_issue_addr;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  item_t ld_q[$];
  item_t st_q[$];
  logic [2:0] exp_tail = 3'd0;

  lsq_disambig i_lsq_disambig (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_store(alloc_store),
    .alloc_idx(alloc_idx), .full(full),
    .addr_valid(addr_valid), .addr_idx(addr_idx), .addr_value(addr_value),
    .commit_valid(commit_valid), .commit_idx(commit_idx),
    .flush_valid(flush_valid), .flush_idx(flush_idx),
    .ld_issue_valid(ld_issue_valid), .ld_issue_idx(ld_issue_idx),
    .ld_issue_addr(ld_issue_addr),
    .st_issue_valid(st_issue_valid), .st_issue_idx(st_issue_idx),
    .st_issue_addr(st_issue_addr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    alloc_valid  = 1'b0;
    addr_valid   = 1'b0;
    commit_valid = 1'b0;
    flush_valid  = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic alloc(input bit st, input string req);
    alloc_valid = 1'b1;
    alloc_store = st;
    chk(alloc_idx == exp_tail, req, "alloc_idx", alloc_idx, exp_tail);
    exp_tail = exp_tail + 3'd1;
    tick();
  endtask

  task automatic set_addr(input logic [2:0] idx, input logic [31:0] a);
    addr_valid = 1'b1;
    addr_idx   = idx;
    addr_value = a;
    tick();
  endtask

  task automatic do_commit(input logic [2:0] idx);
    commit_valid = 1'b1;
    commit_idx   = idx;
    tick();
  endtask

  task automatic do_flush(input logic [2:0] idx);
    flush_valid = 1'b1;
    flush_idx   = idx;
    exp_tail    = idx;
    tick();
  endtask

  task automatic exp_ld(input logic [2:0] idx, input logic [31:0] a);
    ld_q.push_back('{idx: idx, addr: a});
  endtask

  task automatic exp_st(input logic [2:0] idx, input logic [31:0] a);
    st_q.push_back('{idx: idx, addr: a});
  endtask

  task automatic drained(input string req);
    chk(ld_q.size() == 0, req, "pending loads", ld_q.size(), 0);
    chk(st_q.size() == 0, req, "pending stores", st_q.size(), 0);
  endtask

  // Monitor: compares each issue strobe with the oldest expected item.
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (ld_issue_valid) begin
          if (ld_q.size() == 0) begin
            chk(1'b0, cur_req, "unexpected load issue", {ld_issue_idx, ld_issue_addr}, 0);
          end else begin
            it = ld_q.pop_front();
            chk({ld_issue_idx, ld_issue_addr} == it, cur_req, "load issue idx/addr",
                {ld_issue_idx, ld_issue_addr}, it);
          end
        end
        if (st_issue_valid) begin
          if (st_q.size() == 0) begin
            chk(1'b0, cur_req, "unexpected store issue", {st_issue_idx, st_issue_addr}, 0);
          end else begin
            it = st_q.pop_front();
            chk({st_issue_idx, st_issue_addr} == it, cur_req, "store issue idx/addr",
                {st_issue_idx, st_issue_addr}, it);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    alloc_valid = 1'b0; alloc_store = 1'b0;
    addr_valid = 1'b0; addr_idx = '0; addr_value = '0;
    commit_valid = 1'b0; commit_idx = '0;
    flush_valid = 1'b0; flush_idx = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);

    // R1: empty after reset
    cur_req = "R1";
    chk(full == 1'b0, "R1", "full", full, 0);
    chk(alloc_idx == 3'd0, "R1", "alloc_idx", alloc_idx, 0);
    chk(!ld_issue_valid && !st_issue_valid, "R1", "issue strobes",
        {ld_issue_valid, st_issue_valid}, 0);
    tick();

    // R4, R11: lone load issues one cycle after its address
    cur_req = "R4";
    alloc(1'b0, "R2");                 // idx 0
    exp_ld(3'd0, 32'h100);
    set_addr(3'd0, 32'h100);
    idle(3);
    drained("R4");

    // R5: unresolved older store blocks, resolved distinct address releases
    cur_req = "R5";
    alloc(1'b1, "R2");                 // store idx 1
    alloc(1'b0, "R2");                 // load idx 2
    set_addr(3'd2, 32'h200);
    idle(3);                           // no load may issue here
    exp_ld(3'd2, 32'h200);
    set_addr(3'd1, 32'h300);
    exp_st(3'd1, 32'h300);
    do_commit(3'd1);
    idle(4);
    drained("R5");

    // R6: equal address waits for the store to leave
    cur_req = "R6";
    alloc(1'b1, "R2");                 // store idx 3
    alloc(1'b0, "R2");                 // load idx 4
    set_addr(3'd3, 32'h400);
    set_addr(3'd4, 32'h400);
    idle(3);
    exp_st(3'd3, 32'h400);
    exp_ld(3'd4, 32'h400);
    do_commit(3'd3);
    idle(5);
    drained("R6");

    // R8, R7: uncommitted head holds back a committed younger store
    cur_req = "R8";
    alloc(1'b1, "R2");                 // store idx 5
    alloc(1'b1, "R2");                 // store idx 6
    set_addr(3'd5, 32'h500);
    set_addr(3'd6, 32'h600);
    do_commit(3'd6);
    idle(4);
    cur_req = "R7";
    exp_st(3'd5, 32'h500);
    exp_st(3'd6, 32'h600);
    do_commit(3'd5);
    idle(4);
    drained("R7");

    // R10: two eligible loads, oldest first, across the index wrap
    cur_req = "R10";
    alloc(1'b1, "R2");                 // store idx 7
    alloc(1'b0, "R2");                 // load idx 0
    alloc(1'b0, "R2");                 // load idx 1
    set_addr(3'd0, 32'h700);
    set_addr(3'd1, 32'h710);
    idle(3);
    exp_ld(3'd0, 32'h700);
    exp_ld(3'd1, 32'h710);
    set_addr(3'd7, 32'h7F0);
    idle(3);
    exp_st(3'd7, 32'h7F0);
    do_commit(3'd7);
    idle(4);
    drained("R10");

    // R9: partial flush, discarded load never issues, tail rewinds
    cur_req = "R9";
    alloc(1'b0, "R2");                 // load idx 2
    alloc(1'b1, "R2");                 // store idx 3
    alloc(1'b0, "R2");                 // load idx 4
    do_flush(3'd3);
    set_addr(3'd4, 32'h900);           // discarded entry
    idle(3);
    exp_ld(3'd2, 32'h800);
    set_addr(3'd2, 32'h800);
    idle(3);
    alloc(1'b0, "R9");                 // must receive idx 3
    exp_ld(3'd3, 32'h810);
    set_addr(3'd3, 32'h810);
    idle(3);
    drained("R9");

    // R3, R11: fill, ignored allocation, free one slot
    cur_req = "R3";
    for (int i = 0; i < 8; i++) alloc(1'b0, "R2");   // idx 4..7,0..3
    chk(full == 1'b1, "R3", "full after 8 allocs", full, 1);
    alloc_valid = 1'b1;
    alloc_store = 1'b1;
    tick();                            // attempt while full
    chk(full == 1'b1, "R3", "full after ignored alloc", full, 1);
    cur_req = "R11";
    exp_ld(3'd4, 32'hA00);
    set_addr(3'd4, 32'hA00);
    idle(3);
    chk(full == 1'b0, "R11", "full after issued head load left", full, 0);
    alloc(1'b0, "R3");                 // must still receive idx 4
    chk(full == 1'b1, "R3", "full after refill", full, 1);
    cur_req = "R9";
    do_flush(3'd5);                    // head is 5: discard all
    chk(full == 1'b0, "R9", "full after total flush", full, 0);
    chk(alloc_idx == 3'd5, "R9", "alloc_idx after total flush", alloc_idx, 5);
    set_addr(3'd6, 32'hB00);
    idle(3);
    drained("R9");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule